// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the exchange point between a host I/O bus and the embedded CPU inside a keyboard controller. The host sees two locations, selected by one address bit. With the bit low it writes data bytes and reads reply bytes. With the bit high it writes command bytes and reads a status byte. The embedded CPU sees four registers on a small register port: the inbound byte, the outbound byte, the status byte and a control byte.

Two handshake flags keep the two sides in step. The input-full flag is raised by any host write and dropped when the CPU fetches the inbound byte. The output-full flag is raised by a CPU write of the outbound byte and dropped when the host reads it. Every host write also records whether it was a command or a data byte. A level interrupt toward the CPU follows the input-full flag, gated by a CPU-controlled enable.

All strobes are single-cycle: each clock cycle in which a strobe is high counts as one access. Read data is combinational from the registers. A strobe's effect shows in the cycle after its clock edge.

Top module: `kbc_host_mailbox`

## Requirements
- R1: While `rst` is high at a clock edge, every register is loaded with zero: the status byte reads 0x00, the inbound and outbound bytes read 0x00, the interrupt enable is 0 and `cpu_irq` is 0. This holds for as long as `rst` stays high, whatever the strobes do.
- R2: A host read with `host_a2`=0 returns the outbound byte. A host read with `host_a2`=1 returns the status byte. The status layout is: bit 0 output-full, bit 1 input-full, bit 3 command flag, bits 2 and 7:4 user bits.
- R3: A host write stores `host_wdata` as the inbound byte and sets input-full. This holds for either value of `host_a2`. A write while input-full is already set replaces the byte, and the flag stays 1.
- R4: On each host write, the command flag takes the value of `host_a2`. No other access changes it.
- R5: A CPU read at address 0 returns the inbound byte and clears input-full after that edge.
- R6: A CPU write at address 1 stores the outbound byte and sets output-full. A host read with `host_a2`=0 clears output-full. A host status read leaves it unchanged.
- R7: A CPU write at address 2 loads only the user bits (mask 0xF4) from `cpu_wdata`. The output-full, input-full and command flags are not changed by it.
- R8: `cpu_irq` is high exactly when input-full is set and the enable (bit 0 of CPU address 3) is 1. It drops after a CPU read of the inbound byte.
- R9: When a flag's set event and clear event fall in the same cycle, the flag ends up set. For input-full these are a host write and a CPU read at address 0. For output-full these are a CPU write at address 1 and a host data read.
- R10: CPU reads return the inbound byte at address 0, the outbound byte at address 1, the status byte at address 2, and {7'b0, enable} at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_a2 | input | 1 | Host address bit: 0 data, 1 command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 2 | CPU register select |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte |
| cpu_irq | output | 1 | Level interrupt toward the CPU |

## Verification
Each flag can see its raising event and its clearing event in the same cycle. For input-full, that is a host write landing while the CPU fetches the inbound byte. For output-full, that is a CPU reply landing while the host drains the previous one. The bench drives both ports in one cycle for these cases. It checks that the reader got the old byte, that the flag and the interrupt are still high afterwards, and that a later read returns the new byte.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;
    localparam int BYTE_W = 8;

    // Status bit positions
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CD  = 3;
    localparam logic [BYTE_W-1:0] USER_MASK = 8'hF4;

    // CPU register map
    localparam logic [1:0] CPU_IN   = 2'd0;
    localparam logic [1:0] CPU_OUT  = 2'd1;
    localparam logic [1:0] CPU_STAT = 2'd2;
    localparam logic [1:0] CPU_CTRL = 2'd3;

    typedef struct packed {
        logic [BYTE_W-1:0] in_byte;
        logic [BYTE_W-1:0] out_byte;
        logic [BYTE_W-1:0] user_bits;
        logic              cmd_flag;
        logic              irq_en;
    } mbox_state_t;
endpackage

// File: rtl/kbc_flag_cell.sv
module kbc_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // set has priority
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o); // R9
    AST_CLR_ALONE: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o); // R5
endmodule

// File: rtl/kbc_host_decode.sv
module kbc_host_decode (
    input  logic host_cs,
    input  logic host_wr,
    input  logic host_rd,
    input  logic host_a2,
    output logic wr_stb,
    output logic data_rd_stb,
    output logic stat_rd_stb
);
    always_comb begin
        wr_stb      = host_cs && host_wr;
        data_rd_stb = host_cs && host_rd && !host_a2;
        stat_rd_stb = host_cs && host_rd &&  host_a2;
    end
endmodule

// File: rtl/kbc_cpu_decode.sv
module kbc_cpu_decode
    import kbc_mbox_pkg::*;
(
    input  logic       cpu_wr,
    input  logic       cpu_rd,
    input  logic [1:0] cpu_addr,
    output logic       in_rd_stb,
    output logic       out_wr_stb,
    output logic       stat_wr_stb,
    output logic       ctrl_wr_stb
);
    always_comb begin
        in_rd_stb   = cpu_rd && (cpu_addr == CPU_IN);
        out_wr_stb  = cpu_wr && (cpu_addr == CPU_OUT);
        stat_wr_stb = cpu_wr && (cpu_addr == CPU_STAT);
        ctrl_wr_stb = cpu_wr && (cpu_addr == CPU_CTRL);
    end
endmodule

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox
    import kbc_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_a2,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              cpu_irq
);
    logic h_wr, h_data_rd, h_stat_rd;
    logic c_in_rd, c_out_wr, c_stat_wr, c_ctrl_wr;
    logic ibf, obf;
    mbox_state_t st_d, st_q;
    logic [BYTE_W-1:0] status;

    kbc_host_decode u_hdec (
        .host_cs     (host_cs),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_a2     (host_a2),
        .wr_stb      (h_wr),
        .data_rd_stb (h_data_rd),
        .stat_rd_stb (h_stat_rd)
    );

    kbc_cpu_decode u_cdec (
        .cpu_wr      (cpu_wr),
        .cpu_rd      (cpu_rd),
        .cpu_addr    (cpu_addr),
        .in_rd_stb   (c_in_rd),
        .out_wr_stb  (c_out_wr),
        .stat_wr_stb (c_stat_wr),
        .ctrl_wr_stb (c_ctrl_wr)
    );

    kbc_flag_cell u_ibf (
        .clk    (clk),
        .rst    (rst),
        .set_i  (h_wr),
        .clr_i  (c_in_rd),
        .flag_o (ibf)
    );

    kbc_flag_cell u_obf (
        .clk    (clk),
        .rst    (rst),
        .set_i  (c_out_wr),
        .clr_i  (h_data_rd),
        .flag_o (obf)
    );

    always_comb begin
        st_d = st_q;
        if (h_wr) begin
            st_d.in_byte  = host_wdata;
            st_d.cmd_flag = host_a2;
        end
        if (c_out_wr)  st_d.out_byte  = cpu_wdata;
        if (c_stat_wr) st_d.user_bits = cpu_wdata & USER_MASK;
        if (c_ctrl_wr) st_d.irq_en    = cpu_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        status         = st_q.user_bits;
        status[ST_OBF] = obf;
        status[ST_IBF] = ibf;
        status[ST_CD]  = st_q.cmd_flag;
    end

    assign host_rdata = host_a2 ? status : st_q.out_byte;

    always_comb begin
        unique case (cpu_addr)
            CPU_IN:   cpu_rdata = st_q.in_byte;
            CPU_OUT:  cpu_rdata = st_q.out_byte;
            CPU_STAT: cpu_rdata = status;
            default:  cpu_rdata = {{(BYTE_W-1){1'b0}}, st_q.irq_en};
        endcase
    end

    assign cpu_irq = ibf && st_q.irq_en;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (status == '0 && !cpu_irq && st_q.out_byte == '0)); // R1
    AST_IBF_SET: assert property (@(posedge clk) disable iff (rst)
        h_wr |=> status[ST_IBF]); // R3
    AST_CD_FOLLOWS_A2: assert property (@(posedge clk) disable iff (rst)
        h_wr |=> (status[ST_CD] == $past(host_a2))); // R4
    AST_CD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !h_wr |=> $stable(status[ST_CD])); // R4
    AST_OBF_SET: assert property (@(posedge clk) disable iff (rst)
        c_out_wr |=> status[ST_OBF]); // R6
    AST_OBF_STAT_READ: assert property (@(posedge clk) disable iff (rst)
        (h_stat_rd && !h_data_rd) |=> (status[ST_OBF] || !$past(status[ST_OBF]))); // R6
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (c_in_rd && !h_wr) |=> !cpu_irq); // R8
    AST_USER_MASK: assert property (@(posedge clk) disable iff (rst)
        c_stat_wr |=> ((status & USER_MASK) == ($past(cpu_wdata) & USER_MASK))); // R7
endmodule

// File: tb/kbc_host_mailbox_test.sv
module kbc_host_mailbox_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_cs = 0, host_wr = 0, host_rd = 0, host_a2 = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       cpu_wr = 0, cpu_rd = 0;
    logic [1:0] cpu_addr = 0;
    logic [7:0] cpu_wdata = 0, cpu_rdata;
    logic       cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbc_host_mailbox uut (
        .clk(clk), .rst(rst),
        .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd), .host_a2(host_a2),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // One cycle with both ports driven; read data captured before the edge.
    task automatic access(input logic hw, input logic hr, input logic ha2, input logic [7:0] hwd,
                          input logic cw, input logic cr, input logic [1:0] ca, input logic [7:0] cwd,
                          output logic [7:0] hrd, output logic [7:0] crd);
        host_cs = hw | hr; host_wr = hw; host_rd = hr; host_a2 = ha2; host_wdata = hwd;
        cpu_wr = cw; cpu_rd = cr; cpu_addr = ca; cpu_wdata = cwd;
        #1;
        hrd = host_rdata; crd = cpu_rdata;
        @(negedge clk);
        host_cs = 0; host_wr = 0; host_rd = 0; host_a2 = 0;
        cpu_wr = 0; cpu_rd = 0; cpu_addr = 0;
    endtask

    task automatic host_write(input logic a2, input logic [7:0] d);
        logic [7:0] h, c;
        access(1, 0, a2, d, 0, 0, 0, 0, h, c);
    endtask

    task automatic host_read(input logic a2, output logic [7:0] d);
        logic [7:0] c;
        access(0, 1, a2, 0, 0, 0, 0, 0, d, c);
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] h, c;
        access(0, 0, 0, 0, 1, 0, a, d, h, c);
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        logic [7:0] h;
        access(0, 0, 0, 0, 0, 1, a, 0, h, d);
    endtask

    task automatic peek_status(output logic [7:0] s);
        cpu_addr = 2'd2; #1; s = cpu_rdata; cpu_addr = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        // Strobes active during reset must be ignored
        rst = 1;
        host_write(1, 8'hAB);
        cpu_write(1, 8'hCD);
        cpu_write(3, 8'h01);
        peek_status(v);               check("R1 status in reset", v, 8'h00);
        check("R1 irq in reset", {7'b0, cpu_irq}, 8'h00);
        cpu_addr = 0; #1;             check("R1 inbound in reset", cpu_rdata, 8'h00);
        cpu_addr = 1; #1;             check("R1 outbound in reset", cpu_rdata, 8'h00);
        cpu_addr = 3; #1;             check("R1 enable in reset", cpu_rdata, 8'h00);
        cpu_addr = 0;
        @(negedge clk); rst = 0; @(negedge clk);
    endtask

    task automatic t_data_write;
        logic [7:0] v;
        host_write(0, 8'h5A);
        host_read(1, v);              check("R3/R2 status after data write", v, 8'h02);
        cpu_read(0, v);               check("R5/R10 inbound byte", v, 8'h5A);
        peek_status(v);               check("R5 input-full cleared", v, 8'h00);
    endtask

    task automatic t_command;
        logic [7:0] v;
        host_write(1, 8'hD4);
        peek_status(v);               check("R4 command flag set", v, 8'h0A);
        host_write(0, 8'h11);
        peek_status(v);               check("R3/R4 overwrite keeps full, flag to data", v, 8'h02);
        cpu_read(0, v);               check("R3 overwritten byte", v, 8'h11);
        host_write(1, 8'h22);
        cpu_read(0, v);
        peek_status(v);               check("R4 flag kept after CPU read", v, 8'h08);
    endtask

    task automatic t_outbound;
        logic [7:0] v;
        cpu_write(1, 8'h77);
        host_read(1, v);              check("R6 output-full set", v, 8'h09);
        host_read(1, v);              check("R6 status read keeps output-full", v, 8'h09);
        cpu_read(1, v);               check("R10 outbound via CPU", v, 8'h77);
        host_read(0, v);              check("R2 host data read", v, 8'h77);
        host_read(1, v);              check("R6 output-full cleared", v, 8'h08);
    endtask

    task automatic t_user_bits;
        logic [7:0] v;
        host_write(0, 8'h01);
        cpu_write(1, 8'h02);
        cpu_write(2, 8'hFF);
        peek_status(v);               check("R7 user bits set, flags kept", v, 8'hF7);
        cpu_write(2, 8'h0B);
        peek_status(v);               check("R7 flags not writable", v, 8'h03);
        cpu_read(0, v); host_read(0, v);
        peek_status(v);               check("R7 flags cleared normally", v, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        host_write(0, 8'h33);
        check("R8 irq masked", {7'b0, cpu_irq}, 8'h00);
        cpu_write(3, 8'h01);
        cpu_read(3, v);               check("R10 control readback", v, 8'h01);
        check("R8 irq raised by enable", {7'b0, cpu_irq}, 8'h01);
        @(negedge clk);
        check("R8 irq is level", {7'b0, cpu_irq}, 8'h01);
        cpu_read(0, v);
        check("R8 irq dropped by read", {7'b0, cpu_irq}, 8'h00);
        host_write(0, 8'h34);
        check("R8 irq on new byte", {7'b0, cpu_irq}, 8'h01);
        cpu_read(0, v);
    endtask

    task automatic t_collide;
        logic [7:0] h, c, v;
        host_write(0, 8'hA1);
        access(1, 0, 0, 8'hB2, 0, 1, 0, 0, h, c);
        check("R9 CPU got old inbound", c, 8'hA1);
        check("R9 irq held on collide", {7'b0, cpu_irq}, 8'h01);
        peek_status(v);               check("R9 input-full wins", v, 8'h02);
        cpu_read(0, v);               check("R9 new inbound", v, 8'hB2);
        cpu_write(1, 8'hC3);
        access(0, 1, 0, 0, 1, 0, 1, 8'hD4, h, c);
        check("R9 host got old outbound", h, 8'hC3);
        peek_status(v);               check("R9 output-full wins", v, 8'h01);
        host_read(0, v);              check("R9 new outbound", v, 8'hD4);
    endtask

    task automatic t_reset_mid;
        logic [7:0] v;
        host_write(1, 8'h44); cpu_write(1, 8'h55); cpu_write(2, 8'hF0);
        rst = 1;
        repeat (3) @(negedge clk);
        peek_status(v);               check("R1 mid-run reset status", v, 8'h00);
        check("R1 mid-run reset irq", {7'b0, cpu_irq}, 8'h00);
        rst = 0; @(negedge clk);
        host_read(0, v);              check("R1 outbound cleared", v, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_data_write();
        t_command();
        t_outbound();
        t_user_bits();
        t_irq();
        t_collide();
        t_reset_mid();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule